// File: doc/BRIEF.md
# Receive Packet FIFO Status Tracker

This block keeps the books for a receive byte FIFO that a host empties by programmed I/O. The MAC side presents one byte per cycle together with an end-of-frame marker and, on the last byte, a MAC-detected error code. The tracker models only how full the FIFO is. It queues one status entry per completed frame and presents the status of the oldest frame as a single 16-bit word. It also drives the FIFO diagnostic flags: receiving, byte-FIFO overrun, status-queue overrun, and read underrun. Read underrun also drives the adapter-failure output.

The host reads bytes of the oldest frame with a read strobe. It drops that frame, together with any of its bytes it has not read, with a discard command. A receive-reset command returns the whole tracker to its empty state. Frames are accepted or refused as a whole when their first byte arrives. If the byte FIFO fills part-way through a frame, the rest of that frame is cut off and the frame is marked as overrun.

Top module: `rxq_status_tracker`

## Requirements
- R1: While the status queue is empty, `rx_status` reads bit 15 = 1, bits 14:11 = 0, and bits 10:0 = the number of bytes stored so far for the frame being received (0 when no frame is in progress).
- R2: While the queue holds at least one frame, `rx_status` reads bit 15 = 0, bits 14:11 = the oldest frame's 4-bit error code, and bits 10:0 = its stored byte count.
- R3: The error code queued with a frame is chosen by priority. Overrun (4'b1000) comes first. Next is a non-zero `mac_err_code` sampled with the last byte; the intended values are 4'b1011 runt, 4'b1100 alignment, 4'b1101 CRC and 4'b0010 dribble. Next is oversize (4'b1001), used when the stored count exceeds MAX_LEN. Otherwise the code is 4'b0000.
- R4: `flag_receiving` goes high in the cycle after the first stored byte of a frame of two or more bytes, and goes low in the cycle after its last byte.
- R5: `free_bytes` equals FIFO_BYTES minus the bytes stored and not yet read or discarded. It never exceeds FIFO_BYTES.
- R6: A byte that arrives while the FIFO is full sets `flag_rx_ovr`. The rest of that frame is not stored, and the frame is queued with the overrun code. No new frame is accepted while the flag is set. The flag clears as soon as `free_bytes` exceeds RESUME_FREE.
- R7: `flag_status_ovr` is high exactly while MAX_PKTS frames are queued. A frame that starts while it is high is refused and stores no bytes. Discarding a frame clears the flag.
- R8: A `host_rd` pulse sets the sticky `flag_rx_underrun` and `adapter_fail` if the queue is empty or the oldest frame has been fully read. Only `cmd_rx_reset` or `rst_n` clears these flags. A `host_rd` in the same cycle as `cmd_discard` is ignored.
- R9: `cmd_discard` removes the oldest frame and returns its unread bytes to `free_bytes`. On an empty queue it has no effect.
- R10: `rx_complete` pulses for one cycle, in the cycle after a frame's last byte, only if the queue was empty before that frame was queued.
- R11: `cmd_rx_reset` empties the queue and the byte FIFO, clears every flag, and abandons any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_wr | input | 1 | One received byte this cycle |
| mac_eof | input | 1 | Qualifies `mac_wr`: this byte ends the frame |
| mac_err_code | input | 4 | MAC error code, sampled with the last byte |
| host_rd | input | 1 | Host reads one byte of the oldest frame |
| cmd_discard | input | 1 | Drop the oldest frame |
| cmd_rx_reset | input | 1 | Synchronous receive-side reset |
| rx_status | output | 16 | Status word of the oldest frame, or of the frame in progress |
| rx_complete | output | 1 | One-cycle pulse: first frame ready |
| flag_receiving | output | 1 | A frame is being stored |
| flag_rx_ovr | output | 1 | Byte FIFO overrun |
| flag_status_ovr | output | 1 | Status queue full |
| flag_rx_underrun | output | 1 | Host read past available data (sticky) |
| adapter_fail | output | 1 | Failure indication caused by underrun |
| free_bytes | output | clog2(FIFO_BYTES+1) | Free space in the byte FIFO |
| pkt_count | output | clog2(MAX_PKTS+1) | Frames queued |

## Verification
The assertions check on every cycle the invariants that hold regardless of traffic. These are the shape of the status word against the queue count, the equivalence of the queue-full flag with the count, the bound on free space, and the one-step change of the count. They also check that the underrun flag stays set, that free space never falls while the overrun flag is set, and which preceding inputs may raise the receiving, underrun and completion outputs. The bench scenarios show the things that need a history of traffic. These are the exact byte counts and error-code priority for sweeps of frame lengths and codes, the refusal of whole frames, the point at which the overrun flag clears, the return of unread bytes on discard, and the effect of a receive reset.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

  // Width of the byte-count field in the status word.
  localparam int unsigned LEN_W = 11;

  localparam logic [3:0] CODE_NONE     = 4'b0000;
  localparam logic [3:0] CODE_OVERRUN  = 4'b1000;
  localparam logic [3:0] CODE_OVERSIZE = 4'b1001;

  typedef struct packed {
    logic [3:0]       code;
    logic [LEN_W-1:0] len;
  } pkt_entry_t;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_RECV = 2'd1,
    FR_DROP = 2'd2
  } frame_state_e;

endpackage

// File: rtl/rxq_frame_ctl.sv
`timescale 1ns/1ps
// Write-side frame tracking: accepts or refuses frames, counts stored bytes,
// builds the status entry at end of frame.
module rxq_frame_ctl
  import rxq_pkg::*;
#(
  parameter int unsigned MAX_LEN = 1514
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             mac_wr,
  input  logic             mac_eof,
  input  logic [3:0]       mac_err_code,
  input  logic             space_ok,
  input  logic             queue_full,
  input  logic             ovr_flag,
  output logic             byte_store,
  output logic             ovr_hit,
  output logic             push,
  output pkt_entry_t       push_entry,
  output logic             receiving,
  output logic [LEN_W-1:0] cur_len
);

  localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);

  frame_state_e     state_q, state_d;
  logic [LEN_W-1:0] len_q, len_d, len_now;
  logic             ovr_q, ovr_d, frame_ovr;
  logic             len_cap;
  logic [3:0]       code_sel;

  always_comb begin
    state_d    = state_q;
    byte_store = 1'b0;
    ovr_hit    = 1'b0;
    push       = 1'b0;
    frame_ovr  = ovr_q;
    len_cap    = &len_q;

    unique case (state_q)
      FR_IDLE: begin
        if (mac_wr) begin
          if (queue_full || ovr_flag) begin
            if (!mac_eof) state_d = FR_DROP;
          end else if (!space_ok) begin
            ovr_hit = 1'b1;
            if (!mac_eof) state_d = FR_DROP;
          end else begin
            byte_store = 1'b1;
            if (mac_eof) push = 1'b1;
            else         state_d = FR_RECV;
          end
        end
      end
      FR_RECV: begin
        if (mac_wr) begin
          if (!ovr_q && !len_cap) begin
            if (space_ok) begin
              byte_store = 1'b1;
            end else begin
              ovr_hit   = 1'b1;
              frame_ovr = 1'b1;
            end
          end
          if (mac_eof) begin
            push    = 1'b1;
            state_d = FR_IDLE;
          end
        end
      end
      FR_DROP: begin
        if (mac_wr && mac_eof) state_d = FR_IDLE;
      end
      default: state_d = FR_IDLE;
    endcase

    len_now = len_q + LEN_W'(byte_store);

    if (frame_ovr)                  code_sel = CODE_OVERRUN;
    else if (mac_err_code != 4'd0)  code_sel = mac_err_code;
    else if (len_now > LEN_LIMIT)   code_sel = CODE_OVERSIZE;
    else                            code_sel = CODE_NONE;

    push_entry.code = code_sel;
    push_entry.len  = len_now;

    if (state_d == FR_RECV && !push) begin
      len_d = len_now;
      ovr_d = frame_ovr;
    end else begin
      len_d = '0;
      ovr_d = 1'b0;
    end

    if (clr) begin
      state_d    = FR_IDLE;
      len_d      = '0;
      ovr_d      = 1'b0;
      byte_store = 1'b0;
      ovr_hit    = 1'b0;
      push       = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      len_q   <= '0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      ovr_q   <= ovr_d;
    end
  end

  assign receiving = (state_q == FR_RECV);
  assign cur_len   = len_q;

endmodule

// File: rtl/rxq_status_queue.sv
`timescale 1ns/1ps
// Circular queue of per-frame status entries.
module rxq_status_queue
  import rxq_pkg::*;
#(
  parameter  int unsigned SLOTS = 8,
  localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  pkt_entry_t       push_entry,
  input  logic             pop,
  output pkt_entry_t       head_entry,
  output logic [CNT_W-1:0] count
);

  localparam int unsigned PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(SLOTS - 1);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  pkt_entry_t       slot_rd [SLOTS];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    pkt_entry_t entry_q;
    logic       wr_en;
    assign wr_en = push && (wr_ptr_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (wr_en) entry_q <= push_entry;
    end
    assign slot_rd[g] = entry_q;
  end

  always_comb begin
    wr_ptr_d = push ? ptr_next(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? ptr_next(rd_ptr_q) : rd_ptr_q;
    count_d  = count_q + CNT_W'(push) - CNT_W'(pop);
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  assign head_entry = slot_rd[rd_ptr_q];
  assign count      = count_q;

endmodule

// File: rtl/rxq_occupancy.sv
`timescale 1ns/1ps
// Byte FIFO occupancy, host read position, overrun and underrun flags.
module rxq_occupancy
  import rxq_pkg::*;
#(
  parameter  int unsigned FIFO_BYTES  = 2048,
  parameter  int unsigned RESUME_FREE = 16,
  localparam int unsigned OCC_W       = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             byte_store,
  input  logic             ovr_hit,
  input  logic             host_rd,
  input  logic             discard,
  input  logic             q_empty,
  input  logic [LEN_W-1:0] head_len,
  output logic             pop,
  output logic             space_ok,
  output logic [OCC_W-1:0] free_bytes,
  output logic             rx_ovr,
  output logic             rx_underrun
);

  localparam logic [OCC_W-1:0] CAPACITY = OCC_W'(FIFO_BYTES);
  localparam logic [OCC_W-1:0] RESUME   = OCC_W'(RESUME_FREE);

  logic [OCC_W-1:0] used_q, used_d, free_d;
  logic [LEN_W-1:0] rd_pos_q, rd_pos_d, unread;
  logic             ovr_q, ovr_d, undr_q, undr_d;
  logic             rd_ok, rd_bad, head_done;

  always_comb begin
    head_done = (rd_pos_q == head_len);
    pop       = discard && !q_empty && !clr;
    rd_ok     = host_rd && !discard && !q_empty && !head_done && !clr;
    rd_bad    = host_rd && !discard && (q_empty || head_done) && !clr;
    unread    = head_len - rd_pos_q;

    used_d = used_q + OCC_W'(byte_store) - OCC_W'(rd_ok)
             - (pop ? OCC_W'(unread) : '0);
    rd_pos_d = pop ? '0 : rd_pos_q + LEN_W'(rd_ok);
    free_d   = CAPACITY - used_d;

    if (ovr_hit)                       ovr_d = 1'b1;
    else if (ovr_q && (free_d > RESUME)) ovr_d = 1'b0;
    else                               ovr_d = ovr_q;

    undr_d = undr_q | rd_bad;

    if (clr) begin
      used_d   = '0;
      rd_pos_d = '0;
      ovr_d    = 1'b0;
      undr_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q   <= '0;
      rd_pos_q <= '0;
      ovr_q    <= 1'b0;
      undr_q   <= 1'b0;
    end else begin
      used_q   <= used_d;
      rd_pos_q <= rd_pos_d;
      ovr_q    <= ovr_d;
      undr_q   <= undr_d;
    end
  end

  assign space_ok    = (used_q < CAPACITY);
  assign free_bytes  = CAPACITY - used_q;
  assign rx_ovr      = ovr_q;
  assign rx_underrun = undr_q;

endmodule

// File: rtl/rxq_status_tracker.sv
`timescale 1ns/1ps
module rxq_status_tracker
  import rxq_pkg::*;
#(
  parameter  int unsigned FIFO_BYTES  = 2048,
  parameter  int unsigned MAX_PKTS    = 8,
  parameter  int unsigned RESUME_FREE = 16,
  parameter  int unsigned MAX_LEN     = 1514,
  localparam int unsigned OCC_W       = $clog2(FIFO_BYTES + 1),
  localparam int unsigned CNT_W       = $clog2(MAX_PKTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mac_wr,
  input  logic             mac_eof,
  input  logic [3:0]       mac_err_code,
  input  logic             host_rd,
  input  logic             cmd_discard,
  input  logic             cmd_rx_reset,
  output logic [15:0]      rx_status,
  output logic             rx_complete,
  output logic             flag_receiving,
  output logic             flag_rx_ovr,
  output logic             flag_status_ovr,
  output logic             flag_rx_underrun,
  output logic             adapter_fail,
  output logic [OCC_W-1:0] free_bytes,
  output logic [CNT_W-1:0] pkt_count
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(MAX_PKTS);

  // Asynchronous assertion, synchronous release.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic             byte_store, ovr_hit, push, pop, space_ok;
  logic             q_empty, q_full, receiving, rx_ovr, rx_underrun;
  logic [LEN_W-1:0] cur_len;
  pkt_entry_t       push_entry, head_entry;
  logic [CNT_W-1:0] count;
  logic [OCC_W-1:0] free_cnt;

  assign q_empty = (count == '0);
  assign q_full  = (count == FULL_CNT);

  rxq_frame_ctl #(.MAX_LEN(MAX_LEN)) frame_i (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .clr          (cmd_rx_reset),
    .mac_wr       (mac_wr),
    .mac_eof      (mac_eof),
    .mac_err_code (mac_err_code),
    .space_ok     (space_ok),
    .queue_full   (q_full),
    .ovr_flag     (rx_ovr),
    .byte_store   (byte_store),
    .ovr_hit      (ovr_hit),
    .push         (push),
    .push_entry   (push_entry),
    .receiving    (receiving),
    .cur_len      (cur_len)
  );

  rxq_status_queue #(.SLOTS(MAX_PKTS)) queue_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr        (cmd_rx_reset),
    .push       (push),
    .push_entry (push_entry),
    .pop        (pop),
    .head_entry (head_entry),
    .count      (count)
  );

  rxq_occupancy #(.FIFO_BYTES(FIFO_BYTES), .RESUME_FREE(RESUME_FREE)) occ_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .clr         (cmd_rx_reset),
    .byte_store  (byte_store),
    .ovr_hit     (ovr_hit),
    .host_rd     (host_rd),
    .discard     (cmd_discard),
    .q_empty     (q_empty),
    .head_len    (head_entry.len),
    .pop         (pop),
    .space_ok    (space_ok),
    .free_bytes  (free_cnt),
    .rx_ovr      (rx_ovr),
    .rx_underrun (rx_underrun)
  );

  // Completion pulse and queue-full flag.
  logic complete_q, complete_d, stovr_q, stovr_d;

  always_comb begin
    complete_d = push && q_empty;
    stovr_d    = stovr_q;
    if (pop)                                          stovr_d = 1'b0;
    else if (push && (count == FULL_CNT - CNT_W'(1))) stovr_d = 1'b1;
    if (cmd_rx_reset) begin
      complete_d = 1'b0;
      stovr_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      complete_q <= 1'b0;
      stovr_q    <= 1'b0;
    end else begin
      complete_q <= complete_d;
      stovr_q    <= stovr_d;
    end
  end

  assign rx_status        = q_empty ? {1'b1, 4'b0000, cur_len}
                                    : {1'b0, head_entry.code, head_entry.len};
  assign rx_complete      = complete_q;
  assign flag_receiving   = receiving;
  assign flag_rx_ovr      = rx_ovr;
  assign flag_status_ovr  = stovr_q;
  assign flag_rx_underrun = rx_underrun;
  assign adapter_fail     = rx_underrun;
  assign free_bytes       = free_cnt;
  assign pkt_count        = count;

endmodule

// File: rtl/rxq_status_tracker_chk.sv
`timescale 1ns/1ps
module rxq_status_tracker_chk #(
  parameter  int unsigned FIFO_BYTES = 2048,
  parameter  int unsigned MAX_PKTS   = 8,
  localparam int unsigned OCC_W      = $clog2(FIFO_BYTES + 1),
  localparam int unsigned CNT_W      = $clog2(MAX_PKTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mac_wr,
  input logic             mac_eof,
  input logic             host_rd,
  input logic             cmd_rx_reset,
  input logic [15:0]      rx_status,
  input logic             rx_complete,
  input logic             flag_receiving,
  input logic             flag_rx_ovr,
  input logic             flag_status_ovr,
  input logic             flag_rx_underrun,
  input logic [OCC_W-1:0] free_bytes,
  input logic [CNT_W-1:0] pkt_count
);

  p_empty_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_count == '0) |-> (rx_status[15] && (rx_status[14:11] == 4'd0)));

  p_head_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_count != '0) |-> !rx_status[15]);

  p_recv_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_receiving) |-> ($past(mac_wr) && !$past(mac_eof)));

  p_free_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    free_bytes <= OCC_W'(FIFO_BYTES));

  p_ovr_no_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rx_ovr && !cmd_rx_reset) |=> (free_bytes >= $past(free_bytes)));

  p_status_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_status_ovr == (pkt_count == CNT_W'(MAX_PKTS)));

  p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rx_underrun && !cmd_rx_reset) |=> flag_rx_underrun);

  p_underrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_rx_underrun) |-> $past(host_rd));

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_rx_reset |=> ((int'(pkt_count) - int'($past(pkt_count)) <= 1) &&
                       (int'($past(pkt_count)) - int'(pkt_count) <= 1)));

  p_complete_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_complete |-> (($past(pkt_count) == '0) && (pkt_count == CNT_W'(1))));

endmodule

bind rxq_status_tracker rxq_status_tracker_chk #(
  .FIFO_BYTES (FIFO_BYTES),
  .MAX_PKTS   (MAX_PKTS)
) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .mac_wr           (mac_wr),
  .mac_eof          (mac_eof),
  .host_rd          (host_rd),
  .cmd_rx_reset     (cmd_rx_reset),
  .rx_status        (rx_status),
  .rx_complete      (rx_complete),
  .flag_receiving   (flag_receiving),
  .flag_rx_ovr      (flag_rx_ovr),
  .flag_status_ovr  (flag_status_ovr),
  .flag_rx_underrun (flag_rx_underrun),
  .free_bytes       (free_bytes),
  .pkt_count        (pkt_count)
);

// File: tb/rxq_status_tracker_tb_top.sv
`timescale 1ns/1ps
module rxq_status_tracker_tb_top;

  localparam int unsigned DEPTH  = 64;
  localparam int unsigned PKTS   = 8;
  localparam int unsigned RESUME = 16;
  localparam int unsigned LIMIT  = 40;
  localparam int unsigned OCC_W  = $clog2(DEPTH + 1);
  localparam int unsigned CNT_W  = $clog2(PKTS + 1);

  logic             clk;
  logic             rst_n;
  logic             mac_wr, mac_eof, host_rd, cmd_discard, cmd_rx_reset;
  logic [3:0]       mac_err_code;
  logic [15:0]      rx_status;
  logic             rx_complete, flag_receiving, flag_rx_ovr, flag_status_ovr;
  logic             flag_rx_underrun, adapter_fail;
  logic [OCC_W-1:0] free_bytes;
  logic [CNT_W-1:0] pkt_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  rxq_status_tracker #(
    .FIFO_BYTES (DEPTH),
    .MAX_PKTS   (PKTS),
    .RESUME_FREE(RESUME),
    .MAX_LEN    (LIMIT)
  ) dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .mac_wr           (mac_wr),
    .mac_eof          (mac_eof),
    .mac_err_code     (mac_err_code),
    .host_rd          (host_rd),
    .cmd_discard      (cmd_discard),
    .cmd_rx_reset     (cmd_rx_reset),
    .rx_status        (rx_status),
    .rx_complete      (rx_complete),
    .flag_receiving   (flag_receiving),
    .flag_rx_ovr      (flag_rx_ovr),
    .flag_status_ovr  (flag_status_ovr),
    .flag_rx_underrun (flag_rx_underrun),
    .adapter_fail     (adapter_fail),
    .free_bytes       (free_bytes),
    .pkt_count        (pkt_count)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  function automatic int word(input int code, input int len);
    return (code << 11) | len;
  endfunction

  // Drives a frame; returns at the falling edge after the last byte's edge.
  task automatic send_frame(input int len, input logic [3:0] code, input bit view_empty);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 1 && view_empty) begin
        check("R4", "receiving mid-frame", int'(flag_receiving), 1);
        check("R1", "status mid-frame", int'(rx_status), 32'h8001);
      end
      mac_wr       = 1'b1;
      mac_eof      = (i == len - 1);
      mac_err_code = code;
    end
    @(negedge clk);
    mac_wr = 1'b0; mac_eof = 1'b0; mac_err_code = 4'd0;
  endtask

  task automatic read_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); host_rd = 1'b1;
    end
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic discard_top();
    @(negedge clk); cmd_discard = 1'b1;
    @(negedge clk); cmd_discard = 1'b0;
  endtask

  task automatic rx_reset();
    @(negedge clk); cmd_rx_reset = 1'b1;
    @(negedge clk); cmd_rx_reset = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mac_wr = 1'b0; mac_eof = 1'b0; mac_err_code = 4'd0;
    host_rd = 1'b0; cmd_discard = 1'b0; cmd_rx_reset = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state
    check("R1", "reset status", int'(rx_status), 32'h8000);
    check("R5", "reset free", int'(free_bytes), DEPTH);
    check("R11", "reset count", int'(pkt_count), 0);
    check("R8", "reset underrun", int'(flag_rx_underrun), 0);
    check("R6", "reset ovr", int'(flag_rx_ovr), 0);
    check("R10", "reset complete", int'(rx_complete), 0);

    // Length sweep, clean frames
    for (int n = 1; n <= 12; n++) begin
      send_frame(n, 4'd0, n >= 2);
      check("R10", "complete after first frame", int'(rx_complete), 1);
      check("R2", "head word", int'(rx_status), word(0, n));
      check("R5", "free after store", int'(free_bytes), DEPTH - n);
      check("R4", "receiving after eof", int'(flag_receiving), 0);
      read_bytes(n);
      check("R5", "free after read", int'(free_bytes), DEPTH);
      check("R8", "no underrun on exact read", int'(flag_rx_underrun), 0);
      discard_top();
      check("R9", "empty after discard", int'(rx_status), 32'h8000);
    end

    // MAC error codes
    begin
      logic [3:0] codes [4] = '{4'hB, 4'hC, 4'hD, 4'h2};
      foreach (codes[k]) begin
        send_frame(5, codes[k], 1'b1);
        check("R3", "mac code", int'(rx_status), word(int'(codes[k]), 5));
        discard_top();
        check("R9", "discard returns unread", int'(free_bytes), DEPTH);
      end
    end

    // Oversize and priority
    send_frame(LIMIT + 1, 4'd0, 1'b1);
    check("R3", "oversize", int'(rx_status), word(9, LIMIT + 1));
    discard_top();
    send_frame(LIMIT, 4'd0, 1'b1);
    check("R3", "at limit", int'(rx_status), word(0, LIMIT));
    discard_top();
    send_frame(LIMIT + 1, 4'hD, 1'b1);
    check("R3", "mac code over oversize", int'(rx_status), word(13, LIMIT + 1));
    discard_top();

    // Completion only for the first frame
    send_frame(3, 4'd0, 1'b1);
    check("R10", "first pulse", int'(rx_complete), 1);
    send_frame(4, 4'd0, 1'b0);
    check("R10", "no pulse when waiting", int'(rx_complete), 0);
    check("R2", "oldest stays on top", int'(rx_status), word(0, 3));
    discard_top();
    check("R9", "next on top", int'(rx_status), word(0, 4));
    discard_top();
    discard_top();
    check("R9", "discard on empty count", int'(pkt_count), 0);
    check("R9", "discard on empty free", int'(free_bytes), DEPTH);

    // Byte FIFO overrun
    send_frame(DEPTH + 6, 4'd0, 1'b1);
    check("R6", "ovr flag", int'(flag_rx_ovr), 1);
    check("R6", "free at full", int'(free_bytes), 0);
    check("R3", "overrun code", int'(rx_status), word(8, DEPTH));
    send_frame(3, 4'd0, 1'b0);
    check("R6", "refused frame count", int'(pkt_count), 1);
    read_bytes(RESUME);
    check("R6", "ovr held at threshold", int'(flag_rx_ovr), 1);
    read_bytes(1);
    check("R6", "ovr cleared", int'(flag_rx_ovr), 0);
    check("R5", "free after reads", int'(free_bytes), RESUME + 1);
    send_frame(2, 4'd0, 1'b0);
    check("R6", "accepted after clear", int'(pkt_count), 2);
    discard_top();
    check("R9", "unread returned", int'(free_bytes), DEPTH - 2);
    discard_top();

    // Status queue overrun
    for (int p = 0; p < PKTS; p++) send_frame(2, 4'd0, 1'b0);
    check("R7", "queue full flag", int'(flag_status_ovr), 1);
    send_frame(2, 4'd0, 1'b0);
    check("R7", "refused count", int'(pkt_count), PKTS);
    check("R7", "refused stores nothing", int'(free_bytes), DEPTH - 2 * PKTS);
    discard_top();
    check("R7", "flag cleared", int'(flag_status_ovr), 0);
    check("R9", "count after discard", int'(pkt_count), PKTS - 1);
    for (int p = 1; p < PKTS; p++) discard_top();
    check("R5", "all freed", int'(free_bytes), DEPTH);

    // Underrun and receive reset
    read_bytes(1);
    check("R8", "underrun on empty", int'(flag_rx_underrun), 1);
    check("R8", "adapter fail", int'(adapter_fail), 1);
    send_frame(3, 4'd0, 1'b0);
    read_bytes(3);
    discard_top();
    check("R8", "underrun sticky", int'(flag_rx_underrun), 1);
    send_frame(5, 4'd0, 1'b0);
    rx_reset();
    check("R11", "reset clears underrun", int'(flag_rx_underrun), 0);
    check("R11", "reset empties queue", int'(pkt_count), 0);
    check("R11", "reset frees fifo", int'(free_bytes), DEPTH);
    check("R11", "reset status", int'(rx_status), 32'h8000);
    send_frame(3, 4'd0, 1'b1);
    read_bytes(3);
    @(negedge clk); host_rd = 1'b1; cmd_discard = 1'b1;
    @(negedge clk); host_rd = 1'b0; cmd_discard = 1'b0;
    check("R8", "read with discard ignored", int'(flag_rx_underrun), 0);
    check("R9", "discard with read", int'(pkt_count), 0);
    send_frame(3, 4'd0, 1'b1);
    read_bytes(4);
    check("R8", "over-read underrun", int'(flag_rx_underrun), 1);
    check("R5", "free after over-read", int'(free_bytes), DEPTH);
    rx_reset();
    check("R11", "final reset", int'(adapter_fail), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule